// File: doc/BRIEF.md
# Double-Buffered PWM Compare Bank

This block produces a set of pulse-width-modulated outputs from one shared free-running counter. The counter advances by one on each clock in which the timebase tick input and the run input are both high, and it wraps from its all-ones value back to zero, so one PWM period spans 2^CNT_W ticks. Each channel owns an active compare value. An output goes high once the counter has reached that value, and it is forced low when the counter wraps.

Software changes the duty of a channel by writing a staging ("shadow") register. Each time the counter wraps, the channel copies the shadow value into its active compare register. A write made in the middle of a period therefore only takes effect at the start of the next period, and the current pulse is never cut short or lengthened. The active register can also be written directly. Such a write takes effect on the next clock and may produce a glitch. A two-bit mode register gates each channel: the channel runs only when its compare-enable bit and its PWM-enable bit are both set.

Top module: `pwm_cmp_bank`

## Requirements
- R1: The counter `count_o` increments by one, modulo 2^CNT_W, at each rising clock edge where `tick` and `run` are both high. At every other edge it keeps its value.
- R2: For an enabled channel, the output rises at the first clock edge where `run` is high and the counter already holds the channel's active compare value. With `tick` held high, an active value c gives 255 − c high clocks per 256-clock period (8-bit counter).
- R3: At the clock edge where the counter steps from all-ones to zero, every enabled output is cleared. This clear wins over a coincident match, so an active value of 0xFF never drives the output high.
- R4: At that same wrap edge, an enabled channel copies its shadow value into its active compare register. A shadow write during a period has no effect on that period's pulse.
- R5: A direct write to the active compare register is used from the next clock. If it coincides with a wrap reload, the direct write wins.
- R6: The mode register uses bit 0 as compare enable and bit 1 as PWM enable. Unless both bits are 1, the output is driven low from the next clock and the wrap reload of the shadow value is suppressed.
- R7: While `run` is low, the counter and all enabled outputs hold their values. A match cannot set an output while `run` is low.
- R8: An active-low reset clears the counter, the shadow, active and mode registers of every channel, and all outputs.
- R9: `wr_addr` is {channel index, select}, where the select is in bits [1:0]: 0 = shadow, 1 = active, 2 = mode, and 3 is ignored. A write touches only the addressed channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle timebase enable |
| run | input | 1 | Counter run gate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | CH_AW+2 | Channel index and register select |
| wr_data | input | CNT_W | Write data; the mode register uses bits [1:0] |
| count_o | output | CNT_W | Current counter value |
| pwm_o | output | NUM_CH | One PWM output per channel |

## Verification
The assertions assume that `tick` and `run` are clean synchronous levels and that at most one register write is presented per clock. The stopped-output property also assumes that the mode register is not rewritten in the cycle being checked. The bench drives every input on the falling clock edge, issues one write at a time, and changes `run` only at falling edges where the counter value has been observed. The duty sweep loads both channels only through the shadow path, with complementary values, so that the expected high counts come straight from arithmetic. Direct active writes are issued only while the counter is stopped.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

    typedef enum logic [1:0] {
        SEL_SHADOW = 2'd0,
        SEL_ACTIVE = 2'd1,
        SEL_MODE   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam int MODE_CMP_BIT = 0;
    localparam int MODE_PWM_BIT = 1;
    localparam int MODE_W       = 2;

endpackage

// File: rtl/pwm_tick_counter.sv
module pwm_tick_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       step;

    always_comb begin
        st_d   = st_q;
        step   = tick_i && run_i;
        wrap_o = step && (st_q.cnt == {CNT_W{1'b1}});
        if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R1: one step per qualified tick, modulo the counter width
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i) |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));

    // R1, R7: counter holds without a qualified tick
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && run_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/pwm_reg_decode.sv
module pwm_reg_decode
    import pwm_cmp_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 3
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic [NUM_CH-1:0] wr_shd_o,
    output logic [NUM_CH-1:0] wr_act_o,
    output logic [NUM_CH-1:0] wr_mode_o
);

    localparam int CH_AW = ADDR_W - 2;

    reg_sel_e         sel;
    logic [CH_AW-1:0] ch;

    assign sel = reg_sel_e'(wr_addr_i[1:0]);
    assign ch  = wr_addr_i[ADDR_W-1:2];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        logic hit;
        assign hit          = wr_en_i && (ch == CH_AW'(i));
        assign wr_shd_o[i]  = hit && (sel == SEL_SHADOW);
        assign wr_act_o[i]  = hit && (sel == SEL_ACTIVE);
        assign wr_mode_o[i] = hit && (sel == SEL_MODE);
    end

endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             wrap_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wr_shd_i,
    input  logic             wr_act_i,
    input  logic             wr_mode_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             pwm_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  shd;
        logic [CNT_W-1:0]  act;
        logic [MODE_W-1:0] mode;
        logic              out;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        en;
    logic        match;

    always_comb begin
        st_d  = st_q;
        en    = st_q.mode[MODE_CMP_BIT] && st_q.mode[MODE_PWM_BIT];
        match = run_i && (cnt_i == st_q.act);

        if (wr_shd_i) begin
            st_d.shd = wr_data_i;
        end
        if (en && wrap_i) begin
            st_d.act = st_q.shd;
        end
        if (wr_act_i) begin
            st_d.act = wr_data_i;
        end
        if (wr_mode_i) begin
            st_d.mode = wr_data_i[MODE_W-1:0];
        end

        if (!en || wrap_i) begin
            st_d.out = 1'b0;
        end else if (match) begin
            st_d.out = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = st_q.out;

    // R3: wrap always leaves the output low
    p_wrap_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> !pwm_o);

    // R2: a running match on an enabled channel raises the output
    p_match_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && run_i && !wrap_i && cnt_i == st_q.act) |=> pwm_o);

    // R4: wrap reload takes the pre-wrap shadow value
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wrap_i && !wr_act_i) |=> (st_q.act == $past(st_q.shd)));

    // R5: direct write lands on the next clock
    p_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_act_i |=> (st_q.act == $past(wr_data_i)));

    // R6: disabled channel drives low
    p_disabled_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_o);

    // R7: stopped counter freezes the output
    p_stopped_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !run_i && !wr_mode_i) |=> $stable(pwm_o));

endmodule

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank
    import pwm_cmp_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 8,
    localparam int CH_AW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count_o,
    output logic [NUM_CH-1:0] pwm_o
);

    logic              wrap;
    logic [NUM_CH-1:0] wr_shd;
    logic [NUM_CH-1:0] wr_act;
    logic [NUM_CH-1:0] wr_mode;

    pwm_tick_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .run_i  (run),
        .cnt_o  (count_o),
        .wrap_o (wrap)
    );

    pwm_reg_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_shd_o  (wr_shd),
        .wr_act_o  (wr_act),
        .wr_mode_o (wr_mode)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm_cmp_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (run),
            .wrap_i    (wrap),
            .cnt_i     (count_o),
            .wr_shd_i  (wr_shd[i]),
            .wr_act_i  (wr_act[i]),
            .wr_mode_i (wr_mode[i]),
            .wr_data_i (wr_data),
            .pwm_o     (pwm_o[i])
        );
    end

    // R9: a single strobe reaches at most one register
    p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_shd, wr_act, wr_mode}));

endmodule

// File: tb/pwm_cmp_bank_bench.sv
module pwm_cmp_bank_bench;

    localparam int NUM_CH = 2;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              tick;
    logic              run;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [CNT_W-1:0]  wr_data;
    logic [CNT_W-1:0]  count_o;
    logic [NUM_CH-1:0] pwm_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    pwm_cmp_bank #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W)
    ) u_pwm_cmp_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (run),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .count_o (count_o),
        .pwm_o   (pwm_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the write
    task automatic wr(input int ch, input int sel, input int data);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'((ch << 2) | sel);
        wr_data = CNT_W'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int hi0;
        int hi1;
        int low_seen;
        rst_n   = 1'b0;
        tick    = 1'b0;
        run     = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        check("R8 count after reset", int'(count_o), 0);
        check("R8 outputs after reset", int'(pwm_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: ticks on every third clock
        run = 1'b1;
        for (int i = 0; i < 30; i++) begin
            tick = (i % 3 == 0);
            @(negedge clk);
        end
        tick = 1'b0;
        check("R1 sparse tick count", int'(count_o), 10);

        // R7: stopped counter ignores ticks
        run  = 1'b0;
        tick = 1'b1;
        repeat (20) @(negedge clk);
        check("R7 count held while stopped", int'(count_o), 10);
        tick = 1'b0;

        // configure both channels, R6 mode = 3, R9 addressing
        wr(0, 2, 3);
        wr(1, 2, 3);
        wr(0, 0, 0);
        wr(1, 0, 255);
        run  = 1'b1;
        tick = 1'b1;
        while (count_o != 8'd1) @(negedge clk);
        while (count_o != 8'd0) @(negedge clk);

        // R2, R3, R4: full duty sweep loaded only through the shadow path
        for (int c = 0; c < 256; c++) begin
            hi0 = 0;
            hi1 = 0;
            for (int k = 0; k < 256; k++) begin
                if (pwm_o[0]) hi0++;
                if (pwm_o[1]) hi1++;
                if (k == 0) begin
                    wr_en   = 1'b1;
                    wr_addr = ADDR_W'(0);
                    wr_data = CNT_W'(c + 1);
                end else if (k == 1) begin
                    wr_en   = 1'b1;
                    wr_addr = ADDR_W'(4);
                    wr_data = CNT_W'(255 - (c + 1));
                end else begin
                    wr_en = 1'b0;
                end
                @(negedge clk);
            end
            check("R2 R4 ch0 high clocks", hi0, 255 - c);
            check("R3 R9 ch1 high clocks", hi1, c);
            if (c == 0 || c == 255) begin
                check("R1 period alignment", int'(count_o), 0);
            end
        end
        // now ch0 active = 0, ch1 active = 255

        // R7: stop at 0x10, ch1 low
        while (count_o != 8'h10) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        check("R7 ch1 low before direct write", int'(pwm_o[1]), 0);
        wr(1, 1, 8'h10);
        repeat (3) @(negedge clk);
        check("R7 no set while stopped", int'(pwm_o[1]), 0);
        check("R7 counter frozen", int'(count_o), 8'h10);

        // R5: direct value used right away once running
        run  = 1'b1;
        tick = 1'b0;
        @(negedge clk);
        check("R5 direct write match", int'(pwm_o[1]), 1);
        check("R1 no tick no step", int'(count_o), 8'h10);

        // R6: drop PWM enable on ch1
        wr(1, 2, 1);
        @(negedge clk);
        check("R6 disabled output low", int'(pwm_o[1]), 0);
        check("R9 ch0 untouched", int'(pwm_o[0]), 1);
        wr(1, 0, 8'h40);
        wr(1, 1, 8'h05);
        tick     = 1'b1;
        low_seen = 0;
        while (count_o != 8'h80) begin
            if (pwm_o[1]) low_seen++;
            @(negedge clk);
        end
        while (count_o != 8'h05) begin
            if (pwm_o[1]) low_seen++;
            @(negedge clk);
        end
        run  = 1'b0;
        tick = 1'b0;
        check("R6 held low across wrap", low_seen, 0);
        wr(1, 2, 3);
        run = 1'b1;
        @(negedge clk);
        check("R6 reload suppressed, active kept", int'(pwm_o[1]), 1);

        // R9: select 3 writes nothing
        wr(1, 3, 0);
        @(negedge clk);
        check("R9 select 3 ignored", int'(pwm_o[1]), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule